// File: doc/BRIEF.md
# Float Add Special-Case Resolver

This block is the front stage of a single-precision adder. Each 32-bit operand is sorted into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. The block then looks at the pair of classes. If the sum follows from the classes alone, it produces that sum directly on a bypass path and raises an invalid-operation flag where IEEE-754 calls for one. NaN operands, infinities and zero operands all take the bypass path.

When both operands are nonzero finite numbers, the block raises `proceed` instead. It then hands the downstream alignment and addition stages a sign, an exponent and a mantissa for each operand. The mantissa has its hidden bit set, and denormals are pre-normalized. All outputs are registered, so a result appears one clock after its inputs are sampled.

Top module: `fadd_special_resolve`

## Requirements
- R1: If `op_a` is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is `op_a` with fraction bit 22 set and `invalid`=1. This holds whatever `op_b` is, including another signalling NaN.
- R2: If `op_b` is a signalling NaN and `op_a` is not, the result is `op_b` with fraction bit 22 set, and `invalid`=1.
- R3: With no signalling NaN present, a quiet NaN `op_a` (fraction bit 22 set) is returned unchanged. Otherwise a quiet NaN `op_b` is returned unchanged. In both cases `invalid`=0.
- R4: Two infinities of the same sign return `op_a` with `invalid`=0. Infinities of opposite sign return 0x7FC00000 with `invalid`=1.
- R5: An infinity paired with a zero, denormal or normal returns the infinity operand unchanged.
- R6: Two zeros of the same sign return `op_a`. Zeros of opposite sign return +0, or -0 (0x80000000) when `rnd_mode`=3. The mode encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R7: A zero paired with a nonzero finite operand returns the other operand unchanged.
- R8: When both operands are nonzero and finite: `bypass_valid`=0, `proceed`=1 and `invalid`=0. A normal operand unpacks to mantissa {1, fraction} and an exponent equal to its 8-bit biased exponent field.
- R9: A denormal operand is unpacked by shifting {0, fraction} left until bit 23 is set. Its exponent becomes 1 minus the shift count, in 10-bit two's complement.
- R10: Whenever `bypass_valid`=1, `proceed`=0 and every unpacked output is zero. When `proceed`=1, `bypass_result` is zero.
- R11: Outputs appear one clock after their inputs are sampled. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | Rounding mode (0 RNE, 1 RTZ, 2 +inf, 3 -inf) |
| bypass_valid | output | 1 | Sum resolved without arithmetic |
| bypass_result | output | 32 | Resolved sum |
| invalid | output | 1 | Invalid-operation flag |
| proceed | output | 1 | Operands passed on for arithmetic |
| a_sign | output | 1 | Sign of first operand |
| a_exp | output | 10 | Exponent of first operand (two's complement) |
| a_mant | output | 24 | Mantissa of first operand, hidden bit at 23 |
| b_sign | output | 1 | Sign of second operand |
| b_exp | output | 10 | Exponent of second operand (two's complement) |
| b_mant | output | 24 | Mantissa of second operand, hidden bit at 23 |

## Verification
The block holds no state beyond its output register, so any fault in class decoding, NaN priority or normalization shows up at the ports one clock after the offending operand pair is applied.

- A wrong priority choice appears as a NaN payload taken from the wrong operand.
- A misclassified operand flips `proceed` against `bypass_valid`.
- A normalizer error appears as a mantissa without its hidden bit, or an exponent off by the shift count.

Random pairs are drawn across all six classes for both operands, so every pairing of classes is reached.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;
    localparam int UEXP_W = EXP_W + 2;
    localparam int QBIT   = FRAC_W - 1;

    typedef enum logic [2:0] {
        CL_ZERO, CL_DNORM, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
    } fclass_e;

    typedef struct packed {
        logic                     sign;
        logic signed [UEXP_W-1:0] exp;
        logic [MANT_W-1:0]        mant;
    } unpk_t;

    typedef struct packed {
        logic              bypass;
        logic [WORD_W-1:0] result;
        logic              invalid;
        logic              proceed;
        unpk_t             ua;
        unpk_t             ub;
    } out_t;
endpackage

// File: rtl/fadd_classify.sv
module fadd_classify
    import fadd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fclass_e           cls
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    always_comb begin
        ex = word[WORD_W-2 -: EXP_W];
        fr = word[FRAC_W-1:0];
        if (ex == '0)
            cls = (fr == '0) ? CL_ZERO : CL_DNORM;
        else if (ex == '1) begin
            if (fr == '0)    cls = CL_INF;
            else if (fr[QBIT]) cls = CL_QNAN;
            else             cls = CL_SNAN;
        end else
            cls = CL_NORM;
    end
endmodule

// File: rtl/fadd_unpack.sv
module fadd_unpack
    import fadd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output unpk_t             u
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    int                msb;
    int                sh;

    always_comb begin
        ex  = word[WORD_W-2 -: EXP_W];
        fr  = word[FRAC_W-1:0];
        msb = 0;
        for (int i = 0; i < FRAC_W; i++)
            if (fr[i]) msb = i;
        sh  = FRAC_W - msb;
        u.sign = word[WORD_W-1];
        if (ex != '0) begin
            u.exp  = UEXP_W'({2'b00, ex});
            u.mant = {1'b1, fr};
        end else if (fr != '0) begin
            u.exp  = UEXP_W'(1 - sh);
            u.mant = {1'b0, fr} << sh;
        end else begin
            u.exp  = '0;
            u.mant = '0;
        end
    end
endmodule

// File: rtl/fadd_resolve.sv
module fadd_resolve
    import fadd_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  fclass_e           ca,
    input  fclass_e           cb,
    input  logic [1:0]        rm,
    output logic              bypass,
    output logic [WORD_W-1:0] result,
    output logic              invalid
);
    localparam logic [WORD_W-1:0] QMASK   = WORD_W'(1) << QBIT;
    localparam logic [WORD_W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, QMASK[FRAC_W-1:0]};
    localparam logic [1:0]        RM_DOWN = 2'd3;

    logic a_fin, b_fin;

    always_comb begin
        a_fin   = (ca == CL_NORM) || (ca == CL_DNORM);
        b_fin   = (cb == CL_NORM) || (cb == CL_DNORM);
        bypass  = 1'b1;
        invalid = 1'b0;
        result  = '0;
        if (ca == CL_SNAN) begin
            result  = a | QMASK;
            invalid = 1'b1;
        end else if (cb == CL_SNAN) begin
            result  = b | QMASK;
            invalid = 1'b1;
        end else if (ca == CL_QNAN)
            result = a;
        else if (cb == CL_QNAN)
            result = b;
        else if (ca == CL_INF && cb == CL_INF) begin
            if (a[WORD_W-1] == b[WORD_W-1])
                result = a;
            else begin
                result  = DEF_NAN;
                invalid = 1'b1;
            end
        end else if (ca == CL_INF)
            result = a;
        else if (cb == CL_INF)
            result = b;
        else if (ca == CL_ZERO && cb == CL_ZERO) begin
            if (a[WORD_W-1] == b[WORD_W-1])
                result = a;
            else
                result = {(rm == RM_DOWN), {(WORD_W-1){1'b0}}};
        end else if (ca == CL_ZERO)
            result = b;
        else if (cb == CL_ZERO)
            result = a;
        else if (a_fin && b_fin)
            bypass = 1'b0;
    end
endmodule

// File: rtl/fadd_special_resolve.sv
module fadd_special_resolve
    import fadd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WORD_W-1:0]        op_a,
    input  logic [WORD_W-1:0]        op_b,
    input  logic [1:0]               rnd_mode,
    output logic                     bypass_valid,
    output logic [WORD_W-1:0]        bypass_result,
    output logic                     invalid,
    output logic                     proceed,
    output logic                     a_sign,
    output logic signed [UEXP_W-1:0] a_exp,
    output logic [MANT_W-1:0]        a_mant,
    output logic                     b_sign,
    output logic signed [UEXP_W-1:0] b_exp,
    output logic [MANT_W-1:0]        b_mant
);
    localparam int NOPS = 2;

    logic [WORD_W-1:0] ops [NOPS];
    fclass_e           cls [NOPS];
    unpk_t             unp [NOPS];
    logic              byp_w, inv_w;
    logic [WORD_W-1:0] res_w;
    out_t              out_d, out_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        fadd_classify u_cls (.word(ops[i]), .cls(cls[i]));
        fadd_unpack   u_unp (.word(ops[i]), .u(unp[i]));
    end

    fadd_resolve u_res (
        .a(op_a), .b(op_b), .ca(cls[0]), .cb(cls[1]), .rm(rnd_mode),
        .bypass(byp_w), .result(res_w), .invalid(inv_w)
    );

    always_comb begin
        out_d         = '0;
        out_d.bypass  = byp_w;
        out_d.invalid = inv_w;
        out_d.proceed = !byp_w;
        if (byp_w)
            out_d.result = res_w;
        else begin
            out_d.ua = unp[0];
            out_d.ub = unp[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bypass_valid  = out_q.bypass;
    assign bypass_result = out_q.result;
    assign invalid       = out_q.invalid;
    assign proceed       = out_q.proceed;
    assign a_sign        = out_q.ua.sign;
    assign a_exp         = out_q.ua.exp;
    assign a_mant        = out_q.ua.mant;
    assign b_sign        = out_q.ub.sign;
    assign b_exp         = out_q.ub.exp;
    assign b_mant        = out_q.ub.mant;

    // R1 R2 R4
    invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> bypass_valid && (&bypass_result[WORD_W-2 -: EXP_W]) && bypass_result[QBIT]);

    // R8 R9
    hidden_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proceed |-> a_mant[MANT_W-1] && b_mant[MANT_W-1] && !invalid);

    // R10
    bypass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_valid |-> !proceed && a_mant == '0 && b_mant == '0 && a_exp == '0 && b_exp == '0);

    // R6
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_a[WORD_W-2:0] == '0 && op_b[WORD_W-2:0] == '0
                               && op_a[WORD_W-1] != op_b[WORD_W-1]))
        |-> bypass_result == {($past(rnd_mode) == 2'd3), {(WORD_W-1){1'b0}}});

    // R3
    qnan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((&op_a[WORD_W-2 -: EXP_W]) && op_a[QBIT]
                               && !((&op_b[WORD_W-2 -: EXP_W]) && !op_b[QBIT] && op_b[FRAC_W-1:0] != '0)))
        |-> bypass_result == $past(op_a) && !invalid);
endmodule

// File: tb/tb_fadd_special_resolve.sv
module tb_fadd_special_resolve;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  rnd_mode = '0;
    logic        bypass_valid, invalid, proceed, a_sign, b_sign;
    logic [31:0] bypass_result;
    logic signed [9:0] a_exp, b_exp;
    logic [23:0] a_mant, b_mant;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fadd_special_resolve dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .rnd_mode(rnd_mode),
        .bypass_valid(bypass_valid), .bypass_result(bypass_result), .invalid(invalid),
        .proceed(proceed), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant)
    );

    // 0 zero, 1 denorm, 2 norm, 3 inf, 4 qnan, 5 snan
    function automatic int kind(input logic [31:0] w);
        if (w[30:23] == 8'h00) return (w[22:0] == 0) ? 0 : 1;
        if (w[30:23] != 8'hFF) return 2;
        if (w[22:0] == 0) return 3;
        return w[22] ? 4 : 5;
    endfunction

    function automatic logic [34:0] unpk(input logic [31:0] w);
        logic [23:0] m;
        logic signed [9:0] e;
        if (w[30:23] != 0) begin
            m = {1'b1, w[22:0]};
            e = {2'b00, w[30:23]};
        end else begin
            m = {1'b0, w[22:0]};
            e = 10'sd1;
            while (!m[23]) begin
                m = m << 1;
                e = e - 10'sd1;
            end
        end
        return {w[31], e, m};
    endfunction

    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                         output logic [104:0] exp_v, output string tag);
        int ka, kb;
        logic byp, inv;
        logic [31:0] r;
        ka = kind(a); kb = kind(b);
        byp = 1; inv = 0; r = 0;
        if (ka == 5) begin r = a | 32'h0040_0000; inv = 1; tag = "R1"; end
        else if (kb == 5) begin r = b | 32'h0040_0000; inv = 1; tag = "R2"; end
        else if (ka == 4) begin r = a; tag = "R3"; end
        else if (kb == 4) begin r = b; tag = "R3"; end
        else if (ka == 3 && kb == 3) begin
            tag = "R4";
            if (a[31] == b[31]) r = a; else begin r = 32'h7FC0_0000; inv = 1; end
        end
        else if (ka == 3) begin r = a; tag = "R5"; end
        else if (kb == 3) begin r = b; tag = "R5"; end
        else if (ka == 0 && kb == 0) begin
            tag = "R6";
            r = (a[31] == b[31]) ? a : {rm == 2'd3, 31'b0};
        end
        else if (ka == 0) begin r = b; tag = "R7"; end
        else if (kb == 0) begin r = a; tag = "R7"; end
        else begin byp = 0; tag = (ka == 1 || kb == 1) ? "R9" : "R8"; end
        if (byp) exp_v = {1'b1, r, inv, 1'b0, 70'b0};
        else     exp_v = {1'b0, 32'b0, 1'b0, 1'b1, unpk(a), unpk(b)};
    endtask

    function automatic logic [31:0] rand_op();
        logic [31:0] w;
        w = $urandom;
        case ($urandom % 6)
            0: w[30:0] = 0;
            1: begin w[30:23] = 0; if (w[22:0] == 0) w[0] = 1; if ($urandom % 2) w[22:0] = w[22:0] >> ($urandom % 23); if (w[22:0] == 0) w[0] = 1; end
            2: if (w[30:23] == 0 || w[30:23] == 8'hFF) w[30:23] = 8'h80;
            3: begin w[30:23] = 8'hFF; w[22:0] = 0; end
            4: begin w[30:23] = 8'hFF; w[22] = 1; end
            default: begin w[30:23] = 8'hFF; w[22] = 0; if (w[21:0] == 0) w[0] = 1; end
        endcase
        return w;
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm);
        logic [104:0] ev, av;
        string tag;
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = rm;
        model(a, b, rm, ev, tag);
        @(posedge clk);
        @(negedge clk);
        av = {bypass_valid, bypass_result, invalid, proceed, a_sign, a_exp, a_mant, b_sign, b_exp, b_mant};
        checks++;
        // R10 R11: whole output vector compared, including zeroed fields
        if (av !== ev) begin
            errors++;
            $display("FAIL %s a=%h b=%h rm=%0d actual=%h expected=%h", tag, a, b, rm, av, ev);
        end
    endtask

    initial begin
        repeat (20 * NRAND + 1000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        op_a = 32'h7F80_0001; op_b = 32'h3F80_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        // R11: reset holds all outputs at zero
        if ({bypass_valid, bypass_result, invalid, proceed, a_mant, b_mant, a_exp, b_exp} !== '0) begin
            errors++;
            $display("FAIL R11 reset outputs nonzero actual=%h expected=0", bypass_result);
        end
        rst_n = 1'b1;
        apply(32'h7F80_0001, 32'hFF80_0002, 0);  // R1 both SNaN
        apply(32'hFF81_2345, 32'h3F80_0000, 1);  // R1
        apply(32'h3F80_0000, 32'h7F80_0005, 0);  // R2
        apply(32'h7FC0_1234, 32'hFFC0_0001, 0);  // R3 a wins
        apply(32'h0000_0000, 32'hFFE0_0000, 0);  // R3 b
        apply(32'h7F80_0000, 32'h7F80_0000, 0);  // R4 same sign
        apply(32'h7F80_0000, 32'hFF80_0000, 0);  // R4 opposite
        apply(32'h0000_0010, 32'hFF80_0000, 2);  // R5
        for (int m = 0; m < 4; m++) begin
            apply(32'h0000_0000, 32'h8000_0000, 2'(m));  // R6 opposite zeros
            apply(32'h8000_0000, 32'h0000_0000, 2'(m));  // R6
        end
        apply(32'h8000_0000, 32'h8000_0000, 0);  // R6 same sign
        apply(32'h8000_0000, 32'h4049_0FDB, 0);  // R7
        apply(32'h0000_0003, 32'h0000_0000, 0);  // R7 denorm kept as-is
        apply(32'h3F80_0000, 32'hC000_0000, 0);  // R8
        apply(32'h0000_0001, 32'h0040_0000, 0);  // R9 smallest and largest-msb denormals
        apply(32'h807F_FFFF, 32'h0080_0000, 3);  // R9
        for (int n = 0; n < NRAND; n++)
            apply(rand_op(), rand_op(), 2'($urandom % 4));
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        // R11: reset mid-run clears outputs
        if ({bypass_valid, proceed, invalid, bypass_result} !== '0) begin
            errors++;
            $display("FAIL R11 reset clear actual=%h expected=0", bypass_result);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule